// File: doc/BRIEF.md
# Auto-Reload Interval Timer with Compare

This block is an 8-bit up-counting timer for a small microcontroller register bus. Its count rate comes from a source stage, which passes either every system clock or one clock in three, followed by a 7-bit binary prescaler. A 3-bit tap selects a division of 1, 2, 4 and so on up to 128. When the count steps past 255 it does not wrap to zero. It reloads from a software-set reload value, so the interval between overflows is set by the reload value, the tap and the source.

Two sticky flags record events. One records an overflow. The other records a step that lands on a programmed compare value. Each flag drives an interrupt line through its own enable. Software can read the live count at any time through a load register, and a write there replaces the count at once. A control strobe copies the reload value into the counter. Every load of the counter, including the automatic reload, restarts the prescaler and the divide-by-three phase, so counting always resumes from a known point.

All logic runs on one system clock. The source and prescaler stages produce single-cycle enables rather than derived clocks.

Top module: `reload_timer`

Register map (addr): 0 CTRL, 1 SRC, 2 FLAGS, 3 RELOAD, 4 COMPARE, 5 LOAD. Other addresses read 0. CTRL bits: 0 run, 1 overflow interrupt enable, 2 compare interrupt enable, 3 load strobe, 6:4 tap. SRC bits 1:0: value 01 selects divide-by-three and any other value selects the plain clock. FLAGS bits: 0 overflow, 1 compare.

## Requirements
- R1: Each count step adds one to the count, and a read of LOAD (addr 5) returns the live count.
- R2: With SRC[1:0] = 01 a source enable occurs once every three clocks, the first one on the third clock edge after a counter load. Any other SRC value gives an enable on every clock.
- R3: With CTRL[6:4] = n, one count step occurs per 2^n source enables. After a load at edge E, with source period S, steps fall on edges E + m*S*2^n for m = 1, 2, 3 and so on.
- R4: While CTRL[0] (run) is 0, the count, the prescaler and the divide-by-three phase all hold.
- R5: A step taken from a count of 255 loads the RELOAD (addr 3) value instead of 0.
- R6: The overflow flag, FLAGS[0], is set by every reload step of R5. ovf_irq is high exactly while FLAGS[0] and CTRL[1] are both 1.
- R7: The compare flag, FLAGS[1], is set by a step whose new count, including a reload step, equals COMPARE (addr 4). cmp_irq is high exactly while FLAGS[1] and CTRL[2] are both 1.
- R8: Both flags are sticky. A FLAGS write clears each bit written as 0 and leaves each bit written as 1 unchanged. A flag being set in the same cycle takes priority over the clear.
- R9: A write to LOAD puts the written value into the count on that clock edge, whether or not run is set, and overrides any step or load strobe in the same cycle.
- R10: Writing CTRL with bit 3 set copies RELOAD into the count. Bit 3 always reads back as 0.
- R11: Every counter load (R5, R9 or R10) clears the prescaler and the divide-by-three phase.
- R12: Reset sets the count, all flags, all enables, the control fields, RELOAD and COMPARE to 0, and holds both interrupt lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe for one clock |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register, combinational |
| ovf_irq | output | 1 | Overflow interrupt request |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
Directed runs step the count with the plain source at tap 0, with the divide-by-three source, and at a tap of 2. Sampling on both sides of a step edge separates the source period from the prescaler period. A run near 255 with a compare value partway through tells the compare event apart from the overflow event, and it shows that the reload restarts the interval. A load register write made while the prescaler is mid-period checks that the prescaler restarts, and not just that the count changes. Seeded random trials mix reload, compare, start value, source, tap, start method and wait length. Their results are compared with a bench model that counts steps.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;
  localparam int A_CTRL   = 0;
  localparam int A_SRC    = 1;
  localparam int A_FLAGS  = 2;
  localparam int A_RELOAD = 3;
  localparam int A_CMP    = 4;
  localparam int A_LOAD   = 5;

  localparam int C_RUN  = 0;
  localparam int C_OVIE = 1;
  localparam int C_CMIE = 2;
  localparam int C_LOAD = 3;
  localparam int C_TAP  = 4;

  localparam int F_OVF = 0;
  localparam int F_CMP = 1;

  localparam logic [1:0] SRC_DIV = 2'b01;
endpackage

// File: rtl/rtimer_src.sv
module rtimer_src #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic use_div,
  output logic src_en
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] ph_q;
  logic          ph_last;

  assign ph_last = (ph_q == PW'(DIV - 1));
  assign src_en  = run & (use_div ? ph_last : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ph_q <= '0;
    else if (clr) ph_q <= '0;
    else if (run) ph_q <= ph_last ? '0 : ph_q + 1'b1;
  end
endmodule

// File: rtl/rtimer_psc.sv
module rtimer_psc #(
  parameter int PSC_W = 7,
  parameter int TAP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  input  logic [TAP_W-1:0] tap,
  output logic             tick,
  output logic [PSC_W-1:0] psc_q
);
  // A tap of n fires when the low n bits of the prescaler are all ones.
  function automatic logic tap_hit(logic [PSC_W-1:0] v, logic [TAP_W-1:0] t);
    logic [PSC_W-1:0] m;
    m = ~({PSC_W{1'b1}} << t);
    return (v & m) == m;
  endfunction

  assign tick = adv & tap_hit(psc_q, tap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   psc_q <= '0;
    else if (clr) psc_q <= '0;
    else if (adv) psc_q <= psc_q + 1'b1;
  end
endmodule

// File: rtl/rtimer_cnt.sv
module rtimer_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ld_wr,
  input  logic [W-1:0] ld_val,
  input  logic         ld_bit,
  input  logic [W-1:0] reload,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] cnt_q,
  output logic         load_any,
  output logic         wrap_evt,
  output logic         cmp_evt
);
  function automatic logic [W-1:0] step(logic [W-1:0] c, logic [W-1:0] r);
    return (c == {W{1'b1}}) ? r : c + 1'b1;
  endfunction

  logic sw_ld;
  assign sw_ld    = ld_wr | ld_bit;
  assign wrap_evt = tick & ~sw_ld & (cnt_q == {W{1'b1}});
  assign cmp_evt  = tick & ~sw_ld & (step(cnt_q, reload) == cmp_val);
  assign load_any = sw_ld | wrap_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (ld_wr)   cnt_q <= ld_val;
    else if (ld_bit)  cnt_q <= reload;
    else if (tick)    cnt_q <= step(cnt_q, reload);
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rtimer_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PSC_W   = 7,
  parameter int SRC_DV  = 3,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  rd_data,
  output logic              ovf_irq,
  output logic              cmp_irq
);
  localparam int TAP_W = $clog2(PSC_W + 1);

  logic             run_q, ovie_q, cmie_q;
  logic [TAP_W-1:0] tap_q;
  logic [1:0]       src_q;
  logic [CNT_W-1:0] reload_q, cmpv_q, cnt_q;
  logic             ovf_q, cmpf_q;
  logic             sel_ctrl, flag_wr, ld_wr, ld_bit;
  logic             src_en, tick, load_any, wrap_evt, cmp_evt;
  logic [PSC_W-1:0] psc_q;

  assign sel_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
  assign flag_wr  = wr_en && (addr == ADDR_W'(A_FLAGS));
  assign ld_wr    = wr_en && (addr == ADDR_W'(A_LOAD));
  assign ld_bit   = sel_ctrl && wr_data[C_LOAD];

  rtimer_src #(.DIV(SRC_DV)) u_src (
    .clk(clk), .rst_n(rst_n), .run(run_q), .clr(load_any),
    .use_div(src_q == SRC_DIV), .src_en(src_en)
  );

  rtimer_psc #(.PSC_W(PSC_W), .TAP_W(TAP_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .adv(src_en), .clr(load_any),
    .tap(tap_q), .tick(tick), .psc_q(psc_q)
  );

  rtimer_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld_wr(ld_wr), .ld_val(wr_data),
    .ld_bit(ld_bit), .reload(reload_q), .cmp_val(cmpv_q), .cnt_q(cnt_q),
    .load_any(load_any), .wrap_evt(wrap_evt), .cmp_evt(cmp_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; ovie_q <= 1'b0; cmie_q <= 1'b0; tap_q <= '0;
      src_q <= '0; reload_q <= '0; cmpv_q <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(A_CTRL)) begin
        run_q  <= wr_data[C_RUN];
        ovie_q <= wr_data[C_OVIE];
        cmie_q <= wr_data[C_CMIE];
        tap_q  <= wr_data[C_TAP +: TAP_W];
      end
      if (addr == ADDR_W'(A_SRC))    src_q    <= wr_data[1:0];
      if (addr == ADDR_W'(A_RELOAD)) reload_q <= wr_data;
      if (addr == ADDR_W'(A_CMP))    cmpv_q   <= wr_data;
    end
  end

  // Sticky flags: a set in the same cycle wins over a software clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      cmpf_q <= 1'b0;
    end else begin
      ovf_q  <= wrap_evt | (ovf_q  & ~(flag_wr & ~wr_data[F_OVF]));
      cmpf_q <= cmp_evt  | (cmpf_q & ~(flag_wr & ~wr_data[F_CMP]));
    end
  end

  assign ovf_irq = ovf_q & ovie_q;
  assign cmp_irq = cmpf_q & cmie_q;

  always_comb begin
    rd_data = '0;
    case (addr)
      ADDR_W'(A_CTRL): begin
        rd_data[C_RUN]            = run_q;
        rd_data[C_OVIE]           = ovie_q;
        rd_data[C_CMIE]           = cmie_q;
        rd_data[C_TAP +: TAP_W]   = tap_q;
      end
      ADDR_W'(A_SRC):    rd_data[1:0] = src_q;
      ADDR_W'(A_FLAGS): begin
        rd_data[F_OVF] = ovf_q;
        rd_data[F_CMP] = cmpf_q;
      end
      ADDR_W'(A_RELOAD): rd_data = reload_q;
      ADDR_W'(A_CMP):    rd_data = cmpv_q;
      ADDR_W'(A_LOAD):   rd_data = cnt_q;
      default:           rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rtimer_chk.sv
module rtimer_chk #(
  parameter int CNT_W = 8,
  parameter int PSC_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             load_any,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [PSC_W-1:0] psc,
  input logic [CNT_W-1:0] reload,
  input logic             ld_wr,
  input logic [CNT_W-1:0] wdata,
  input logic             ovf,
  input logic             cmpf,
  input logic             wrap,
  input logic             cmp_hit,
  input logic             flag_wr
);
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_any) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_any) |=> ($stable(cnt) && $stable(psc)));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == $past(reload));

  p_ovf_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(wrap));

  p_cmp_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmpf) |-> $past(cmp_hit));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !flag_wr) |=> ovf);

  p_cmp_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpf && !flag_wr) |=> cmpf);

  p_load_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> cnt == $past(wdata));

  p_psc_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_any |=> psc == '0);
endmodule

bind reload_timer rtimer_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .load_any(load_any), .tick(tick),
  .cnt(cnt_q), .psc(psc_q), .reload(reload_q), .ld_wr(ld_wr),
  .wdata(wr_data), .ovf(ovf_q), .cmpf(cmpf_q), .wrap(wrap_evt),
  .cmp_hit(cmp_evt), .flag_wr(flag_wr)
);

// File: tb/reload_timer_bench.sv
module reload_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       ovf_irq, cmp_irq;

  int total = 0;
  int fails = 0;

  reload_timer u_reload_timer (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
  );

  always #5 clk = ~clk;

  localparam int CTRL = 0, SRC = 1, FLAGS = 2, RELOAD = 3, CMP = 4, LOAD = 5;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; the write lands on the next rising edge.
  task automatic wr(int a, int d);
    addr = 3'(a); wr_data = 8'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    addr = 3'(a);
    #1;
    d = int'(rd_data);
  endtask

  task automatic wait_edges(int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic int period(int src, int tap);
    return ((src == 1) ? 3 : 1) << tap;
  endfunction

  function automatic void model(input int start, input int rel, input int cv,
                                input int steps, output int cnt,
                                output bit ov, output bit cm);
    cnt = start; ov = 1'b0; cm = 1'b0;
    for (int i = 0; i < steps; i++) begin
      if (cnt == 255) begin cnt = rel; ov = 1'b1; end
      else cnt = cnt + 1;
      if (cnt == cv) cm = 1'b1;
    end
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    rd(CTRL, v);   check("R12 ctrl", v, 0);
    rd(LOAD, v);   check("R12 count", v, 0);
    rd(FLAGS, v);  check("R12 flags", v, 0);
    rd(RELOAD, v); check("R12 reload", v, 0);
    check("R12 irqs", {ovf_irq, cmp_irq}, 0);

    // Load register while stopped, then hold
    wr(LOAD, 8'h5A);
    rd(LOAD, v); check("R9 load stopped", v, 8'h5A);
    wait_edges(5);
    rd(LOAD, v); check("R4 hold stopped", v, 8'h5A);

    // Load strobe
    wr(RELOAD, 8'h20);
    wr(CTRL, 8'h08);
    rd(LOAD, v); check("R10 strobe load", v, 8'h20);
    rd(CTRL, v); check("R10 strobe reads 0", v, 0);

    // Plain source, tap 0
    wr(CTRL, 8'h09);
    wait_edges(5);
    rd(LOAD, v); check("R1 step per clock", v, 8'h25);
    wr(CTRL, 8'h00);
    rd(LOAD, v); check("R4 stop edge", v, 8'h26);
    wait_edges(10);
    rd(LOAD, v); check("R4 hold after stop", v, 8'h26);

    // Divide-by-three source
    wr(SRC, 1);
    wr(CTRL, 8'h09);
    wait_edges(8);
    rd(LOAD, v); check("R2 div3 before third step", v, 8'h22);
    wait_edges(1);
    rd(LOAD, v); check("R2 div3 third step", v, 8'h23);
    wr(CTRL, 8'h00);

    // Tap 2
    wr(SRC, 0);
    wr(CTRL, 8'h29);
    wait_edges(13);
    rd(LOAD, v); check("R3 tap2 at 13", v, 8'h23);
    wait_edges(3);
    rd(LOAD, v); check("R3 tap2 at 16", v, 8'h24);
    wr(CTRL, 8'h00);

    // Compare and overflow
    wr(FLAGS, 0);
    wr(RELOAD, 8'hF0);
    wr(CMP, 8'hF8);
    wr(CTRL, 8'h0F);
    wait_edges(7);
    rd(FLAGS, v); check("R7 no early compare", v, 0);
    wait_edges(1);
    rd(FLAGS, v); check("R7 compare flag", v, 2);
    check("R7 compare irq", cmp_irq, 1);
    wait_edges(7);
    rd(LOAD, v);  check("R5 at 255", v, 8'hFF);
    rd(FLAGS, v); check("R6 no early overflow", v, 2);
    wait_edges(1);
    rd(LOAD, v);  check("R5 reload value", v, 8'hF0);
    rd(FLAGS, v); check("R6 overflow flag", v, 3);
    check("R6 overflow irq", ovf_irq, 1);
    wr(CTRL, 8'h06);
    rd(FLAGS, v); check("R8 flags stay", v, 3);
    wr(CTRL, 8'h00);
    check("R6 R7 irqs gated off", {ovf_irq, cmp_irq}, 0);
    rd(FLAGS, v); check("R8 flags kept ungated", v, 3);
    wr(CTRL, 8'h06);
    check("R6 R7 irqs regated", {ovf_irq, cmp_irq}, 3);
    wr(FLAGS, 8'h01);
    rd(FLAGS, v); check("R8 partial clear", v, 1);
    check("R8 cmp irq cleared", {ovf_irq, cmp_irq}, 2);
    wr(FLAGS, 8'h00);
    rd(FLAGS, v); check("R8 full clear", v, 0);
    check("R8 ovf irq cleared", ovf_irq, 0);

    // Load while running restarts the prescaler (tap 3)
    wr(CTRL, 8'h39);
    wait_edges(5);
    wr(LOAD, 8'h40);
    rd(LOAD, v); check("R9 load running", v, 8'h40);
    wait_edges(7);
    rd(LOAD, v); check("R11 prescaler restarted", v, 8'h40);
    wait_edges(1);
    rd(LOAD, v); check("R11 step after restart", v, 8'h41);

    // Seeded random trials
    for (int t = 0; t < 30; t++) begin
      int rel, cv, st, src, tap, ie, k, ecnt;
      bit use_ld, eov, ecm;
      rel = $urandom_range(0, 255);
      cv  = $urandom_range(0, 255);
      src = $urandom_range(0, 3);
      tap = $urandom_range(0, 7);
      ie  = $urandom_range(0, 3);
      k   = $urandom_range(0, 600);
      use_ld = 1'($urandom_range(0, 1));
      st  = use_ld ? $urandom_range(200, 255) : rel;
      wr(CTRL, 0);
      wr(FLAGS, 0);
      wr(RELOAD, rel);
      wr(CMP, cv);
      wr(SRC, src);
      if (use_ld) begin
        wr(LOAD, st);
        wr(CTRL, 1 | (ie << 1) | (tap << 4));
      end else begin
        wr(CTRL, 8'h09 | (ie << 1) | (tap << 4));
      end
      wait_edges(k);
      model(st, rel, cv, k / period(src, tap), ecnt, eov, ecm);
      rd(LOAD, v);  check("R1 R3 random count", v, ecnt);
      rd(FLAGS, v); check("R5 R7 random flags", v, {30'd0, ecm, eov});
      check("R6 random ovf irq", ovf_irq, eov & ie[0]);
      check("R7 random cmp irq", cmp_irq, ecm & ie[1]);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule